// File: doc/BRIEF.md
# Exception Entry and Vectoring Unit

This block sequences exception entry for a 32-bit processor core. Each cycle it looks at a vector of pending exception causes together with the PC of the instruction being retired. When a cause is accepted, it selects a single cause by fixed priority and computes the handler address from one of two base registers. It also produces a write to one of two link registers and updates the three interrupt-enable status bits. All results appear on registered outputs one clock later.

Causes split into two classes. The debug class holds breakpoint and watchpoint. The ordinary class holds both bus errors, divide-by-zero, the external interrupt and the system call. Debug causes always vector from the debug base. Ordinary causes vector from the normal base, unless the remap control bit redirects them to the debug base. The external interrupt is masked while the global enable is clear. A system call that a host-call path has already serviced bypasses entry and only steps the PC past the instruction. A small configuration port loads the two bases, the remap bit and the enable bits.

Top module: `exc_entry_unit`

## Requirements
- R1: After synchronous reset, every output is zero: both bases, the remap bit, the three enable bits, redir_valid and link_we.
- R2: Exception numbers are breakpoint 1, instruction bus error 2, watchpoint 3, data bus error 4, divide-by-zero 5, interrupt 6 and system call 7; cause_req bit k requests number k. When several are pending, the lowest number wins, and bit 0 is ignored.
- R3: The handler address is base + number*32. Debug causes (1 and 3) always use the debug base.
- R4: Ordinary causes (2, 4, 5, 6, 7) use the debug base when remap_on is 1 and the normal base when it is 0.
- R5: On entry, link_we is 1 and link_pc equals the cur_pc of the request cycle. link_brk is 1 (break-address register) for debug causes and 0 (exception-address register) for ordinary causes.
- R6: On ordinary entry, ie_exc takes the prior ie_glb, ie_glb clears, and ie_brk is unchanged.
- R7: On debug entry, ie_brk takes the prior ie_glb, ie_glb clears, and ie_exc is unchanged.
- R8: Cause 6 is ignored while ie_glb is 0, so a lower-priority pending cause is taken instead.
- R9: When the selected cause is 7 and hostcall_ok is 1, redir_pc is cur_pc+4, redir_cause is 7, link_we is 0, and the enable bits are unchanged. hostcall_ok has no effect for any other cause.
- R10: Configuration writes at address 0 (normal base) and 1 (debug base) keep the upper 24 bits of the data; bits [7:0] of both bases always read zero. Address 2 bit 0 sets remap_on. Address 3 bits [2:0] set {ie_brk, ie_exc, ie_glb}.
- R11: Results are registered. redir_valid is 1 exactly in the cycle after a cycle with an accepted cause, and 0 otherwise.
- R12: A status write (address 3) in the same cycle as an entry is discarded. A base write in that cycle takes effect for later entries only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cause_req | input | 8 | Pending causes, bit k = exception number k |
| cur_pc | input | 32 | PC of the faulting/interrupted instruction |
| hostcall_ok | input | 1 | System call already serviced by host-call path |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| redir_valid | output | 1 | New PC is valid this cycle |
| redir_pc | output | 32 | New PC |
| redir_cause | output | 3 | Exception number taken |
| link_we | output | 1 | Link register write enable |
| link_brk | output | 1 | 1: break-address register, 0: exception-address register |
| link_pc | output | 32 | Return address to write |
| ie_glb | output | 1 | Global interrupt enable |
| ie_exc | output | 1 | Enable saved by ordinary entry |
| ie_brk | output | 1 | Enable saved by debug entry |
| norm_base | output | 32 | Normal exception base |
| dbg_base | output | 32 | Debug exception base |
| remap_on | output | 1 | Ordinary causes vector from debug base |

## Verification
The hardest situation to reach is a collision. One case is an interrupt pending alongside lower-priority causes while the global enable is clear. Another is a host-serviced system call competing with higher-priority causes. The bench reaches these by sweeping all 128 combinations of the seven request bits under every setting of remap, global enable and hostcall_ok. Before each request it preloads the status bits through the configuration port, so each save-and-clear outcome is distinguishable. A directed case issues a status write and a base write in the same cycle as an entry, to show which write is dropped and which takes effect late.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned EXC_BKPT  = 1;
  localparam int unsigned EXC_IBUS  = 2;
  localparam int unsigned EXC_WATCH = 3;
  localparam int unsigned EXC_DBUS  = 4;
  localparam int unsigned EXC_DIV0  = 5;
  localparam int unsigned EXC_IRQ   = 6;
  localparam int unsigned EXC_SCALL = 7;

  typedef enum logic [1:0] {
    CFG_NBASE = 2'd0,
    CFG_DBASE = 2'd1,
    CFG_CTRL  = 2'd2,
    CFG_STAT  = 2'd3
  } cfg_addr_e;

  function automatic logic is_debug_cause(input int unsigned num);
    return (num == EXC_BKPT) || (num == EXC_WATCH);
  endfunction
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel #(
  parameter int unsigned NUM_EXC = 8,
  parameter int unsigned IRQ_NUM = 6,
  localparam int unsigned NUM_W = $clog2(NUM_EXC)
) (
  input  logic [NUM_EXC-1:0] req,
  input  logic               irq_en,
  output logic               hit,
  output logic [NUM_W-1:0]   num
);
  logic [NUM_EXC-1:0] gated;

  // bit 0 is the reset slot and never selected here
  assign gated[0] = 1'b0;
  for (genvar k = 1; k < NUM_EXC; k++) begin : g_gate
    if (k == IRQ_NUM) begin : g_irq
      assign gated[k] = req[k] & irq_en;
    end else begin : g_plain
      assign gated[k] = req[k];
    end
  end

  always_comb begin
    hit = 1'b0;
    num = '0;
    for (int k = NUM_EXC - 1; k >= 1; k--) begin
      if (gated[k]) begin
        hit = 1'b1;
        num = NUM_W'(k);
      end
    end
  end
endmodule

// File: rtl/exc_base_regs.sv
module exc_base_regs
  import exc_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned ALIGN_BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [XLEN-1:0] cfg_wdata,
  output logic [XLEN-1:0] nbase,
  output logic [XLEN-1:0] dbase,
  output logic            remap
);
  localparam int unsigned HI_W = XLEN - ALIGN_BITS;

  logic [HI_W-1:0] nbase_hi, dbase_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      nbase_hi <= '0;
      dbase_hi <= '0;
      remap    <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr_e'(cfg_addr))
        CFG_NBASE: nbase_hi <= cfg_wdata[XLEN-1:ALIGN_BITS];
        CFG_DBASE: dbase_hi <= cfg_wdata[XLEN-1:ALIGN_BITS];
        CFG_CTRL:  remap    <= cfg_wdata[0];
        default:   ;
      endcase
    end
  end

  assign nbase = {nbase_hi, {ALIGN_BITS{1'b0}}};
  assign dbase = {dbase_hi, {ALIGN_BITS{1'b0}}};
endmodule

// File: rtl/exc_ie_state.sv
module exc_ie_state (
  input  logic       clk,
  input  logic       rst,
  input  logic       enter,
  input  logic       enter_dbg,
  input  logic       stat_we,
  input  logic [2:0] stat_wdata,
  output logic       glb,
  output logic       sexc,
  output logic       sbrk
);
  always_ff @(posedge clk) begin
    if (rst) begin
      glb  <= 1'b0;
      sexc <= 1'b0;
      sbrk <= 1'b0;
    end else if (enter) begin
      glb <= 1'b0;
      if (enter_dbg) sbrk <= glb;
      else           sexc <= glb;
    end else if (stat_we) begin
      glb  <= stat_wdata[0];
      sexc <= stat_wdata[1];
      sbrk <= stat_wdata[2];
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned NUM_EXC    = 8,
  parameter int unsigned VEC_SHIFT  = 5,
  parameter int unsigned ALIGN_BITS = 8,
  parameter int unsigned PC_STEP    = 4,
  localparam int unsigned NUM_W     = $clog2(NUM_EXC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXC-1:0] cause_req,
  input  logic [XLEN-1:0]    cur_pc,
  input  logic               hostcall_ok,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [XLEN-1:0]    cfg_wdata,
  output logic               redir_valid,
  output logic [XLEN-1:0]    redir_pc,
  output logic [NUM_W-1:0]   redir_cause,
  output logic               link_we,
  output logic               link_brk,
  output logic [XLEN-1:0]    link_pc,
  output logic               ie_glb,
  output logic               ie_exc,
  output logic               ie_brk,
  output logic [XLEN-1:0]    norm_base,
  output logic [XLEN-1:0]    dbg_base,
  output logic               remap_on
);
  logic             sel_hit;
  logic [NUM_W-1:0] sel_num;
  logic             sel_dbg, sel_host, do_enter;
  logic [XLEN-1:0]  sel_base, vec_pc, next_pc;

  exc_prio_sel #(.NUM_EXC(NUM_EXC), .IRQ_NUM(EXC_IRQ)) u_sel (
    .req    (cause_req),
    .irq_en (ie_glb),
    .hit    (sel_hit),
    .num    (sel_num)
  );

  exc_base_regs #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_base (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .nbase     (norm_base),
    .dbase     (dbg_base),
    .remap     (remap_on)
  );

  assign sel_dbg  = is_debug_cause(int'(sel_num));
  assign sel_host = sel_hit && (int'(sel_num) == EXC_SCALL) && hostcall_ok;
  assign do_enter = sel_hit && !sel_host;

  exc_ie_state u_ie (
    .clk        (clk),
    .rst        (rst),
    .enter      (do_enter),
    .enter_dbg  (sel_dbg),
    .stat_we    (cfg_we && (cfg_addr_e'(cfg_addr) == CFG_STAT)),
    .stat_wdata (cfg_wdata[2:0]),
    .glb        (ie_glb),
    .sexc       (ie_exc),
    .sbrk       (ie_brk)
  );

  always_comb begin
    sel_base = (sel_dbg || remap_on) ? dbg_base : norm_base;
    vec_pc   = sel_base + (XLEN'(sel_num) << VEC_SHIFT);
    next_pc  = sel_host ? (cur_pc + XLEN'(PC_STEP)) : vec_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      redir_cause <= '0;
      link_we     <= 1'b0;
      link_brk    <= 1'b0;
      link_pc     <= '0;
    end else begin
      redir_valid <= sel_hit;
      link_we     <= do_enter;
      if (sel_hit) begin
        redir_pc    <= next_pc;
        redir_cause <= sel_num;
        link_brk    <= sel_dbg;
        link_pc     <= cur_pc;
      end
    end
  end
endmodule

// File: rtl/exc_entry_unit_chk.sv
module exc_entry_unit_chk #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned NUM_EXC   = 8,
  parameter int unsigned VEC_SHIFT = 5,
  parameter int unsigned NUM_W     = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_EXC-1:0] cause_req,
  input logic [XLEN-1:0]    cur_pc,
  input logic               redir_valid,
  input logic [XLEN-1:0]    redir_pc,
  input logic [NUM_W-1:0]   redir_cause,
  input logic               link_we,
  input logic               link_brk,
  input logic [XLEN-1:0]    link_pc,
  input logic               ie_glb,
  input logic               ie_exc,
  input logic               ie_brk,
  input logic [XLEN-1:0]    norm_base,
  input logic [XLEN-1:0]    dbg_base
);
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (redir_valid && redir_cause == NUM_W'(6)) |-> $past(ie_glb));

  p_link_pc_r5: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_pc == $past(cur_pc)));

  p_link_class_r5: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_brk == (redir_cause == NUM_W'(1) || redir_cause == NUM_W'(3))));

  p_glb_clear_r6: assert property (@(posedge clk) disable iff (rst)
    link_we |-> !ie_glb);

  p_save_exc_r6: assert property (@(posedge clk) disable iff (rst)
    (link_we && !link_brk) |-> (ie_exc == $past(ie_glb) && ie_brk == $past(ie_brk)));

  p_save_brk_r7: assert property (@(posedge clk) disable iff (rst)
    (link_we && link_brk) |-> (ie_brk == $past(ie_glb) && ie_exc == $past(ie_exc)));

  p_dbg_vec_r3: assert property (@(posedge clk) disable iff (rst)
    (link_we && link_brk) |->
      (redir_pc == $past(dbg_base) + (XLEN'(redir_cause) << VEC_SHIFT)));

  p_host_r9: assert property (@(posedge clk) disable iff (rst)
    (redir_valid && !link_we) |->
      (redir_cause == NUM_W'(7) && redir_pc == $past(cur_pc) + XLEN'(4)));

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    ($past(cause_req[NUM_EXC-1:1]) == '0) |-> !redir_valid);

  p_align_r10: assert property (@(posedge clk) disable iff (rst)
    (norm_base[7:0] == 8'h0 && dbg_base[7:0] == 8'h0));
endmodule

bind exc_entry_unit exc_entry_unit_chk #(
  .XLEN(XLEN), .NUM_EXC(NUM_EXC), .VEC_SHIFT(VEC_SHIFT), .NUM_W(NUM_W)
) u_chk (
  .clk(clk), .rst(rst), .cause_req(cause_req), .cur_pc(cur_pc),
  .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_cause(redir_cause),
  .link_we(link_we), .link_brk(link_brk), .link_pc(link_pc),
  .ie_glb(ie_glb), .ie_exc(ie_exc), .ie_brk(ie_brk),
  .norm_base(norm_base), .dbg_base(dbg_base)
);

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NB = 32'h1234_5600;
  localparam logic [31:0] DB = 32'hABCD_EF00;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  cause_req;
  logic [31:0] cur_pc;
  logic        hostcall_ok;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        redir_valid, link_we, link_brk, ie_glb, ie_exc, ie_brk, remap_on;
  logic [31:0] redir_pc, link_pc, norm_base, dbg_base;
  logic [2:0]  redir_cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_unit u_exc_entry_unit (
    .clk(clk), .rst(rst), .cause_req(cause_req), .cur_pc(cur_pc),
    .hostcall_ok(hostcall_ok), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .redir_cause(redir_cause), .link_we(link_we), .link_brk(link_brk),
    .link_pc(link_pc), .ie_glb(ie_glb), .ie_exc(ie_exc), .ie_brk(ie_brk),
    .norm_base(norm_base), .dbg_base(dbg_base), .remap_on(remap_on)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cause_req = '0; cur_pc = '0; hostcall_ok = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    #1;
    tick(); tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 norm_base", norm_base, 0);
    chk("R1 dbg_base", dbg_base, 0);
    chk("R1 remap", {31'b0, remap_on}, 0);
    chk("R1 ie", {29'b0, ie_brk, ie_exc, ie_glb}, 0);
    chk("R1 redir_valid", {31'b0, redir_valid}, 0);
    chk("R1 link_we", {31'b0, link_we}, 0);

    // R10 alignment of base writes
    cfg(2'd0, NB | 32'hFF);
    cfg(2'd1, DB | 32'hA5);
    chk("R10 norm_base aligned", norm_base, NB);
    chk("R10 dbg_base aligned", dbg_base, DB);

    for (int rm = 0; rm < 2; rm++) begin
      cfg(2'd2, 32'(rm));
      chk("R10 remap bit", {31'b0, remap_on}, 32'(rm));
      for (int ie = 0; ie < 2; ie++) begin
        for (int hc = 0; hc < 2; hc++) begin
          for (int r = 0; r < 256; r++) begin
            logic [2:0] st;
            logic [31:0] pc, base, epc;
            int num;
            bit dbg, host;
            st = {r[1] ^ hc[0], r[2] ^ r[3], ie[0]};
            cfg(2'd3, {29'b0, st});
            pc = 32'h0004_0000 + 32'(r * 4 + ie * 1024 + hc * 2048 + rm * 4096);
            cause_req = r[7:0]; cur_pc = pc; hostcall_ok = hc[0];
            tick();
            cause_req = '0; hostcall_ok = 1'b0;
            // expected model
            num = 0;
            for (int k = 7; k >= 1; k--)
              if (r[k] && !(k == 6 && ie == 0)) num = k;
            dbg  = (num == 1 || num == 3);
            host = (num == 7 && hc == 1);
            base = (dbg || rm == 1) ? DB : NB;
            epc  = host ? pc + 4 : base + 32'(num * 32);
            chk("R11 R2 R8 redir_valid", {31'b0, redir_valid}, {31'b0, num != 0});
            if (num != 0) begin
              chk("R2 R8 redir_cause", {29'b0, redir_cause}, 32'(num));
              chk(dbg ? "R3 pc" : (host ? "R9 pc" : "R4 pc"), redir_pc, epc);
              chk("R5 R9 link_we", {31'b0, link_we}, {31'b0, !host});
              if (!host) begin
                chk("R5 link_brk", {31'b0, link_brk}, {31'b0, dbg});
                chk("R5 link_pc", link_pc, pc);
                if (dbg)
                  chk("R7 ie", {29'b0, ie_brk, ie_exc, ie_glb}, {29'b0, st[0], st[1], 1'b0});
                else
                  chk("R6 ie", {29'b0, ie_brk, ie_exc, ie_glb}, {29'b0, st[2], st[0], 1'b0});
              end else begin
                chk("R9 ie unchanged", {29'b0, ie_brk, ie_exc, ie_glb}, {29'b0, st});
              end
            end else begin
              chk("R8 R11 ie unchanged", {29'b0, ie_brk, ie_exc, ie_glb}, {29'b0, st});
            end
          end
        end
      end
    end

    // R12 collision: status write and base write during entry
    cfg(2'd2, 32'd0);
    cfg(2'd3, 32'd1);
    cause_req = 8'h04; cur_pc = 32'h100;
    cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 32'h7;
    tick();
    cfg_we = 1'b0; cause_req = '0;
    chk("R12 status write dropped", {29'b0, ie_brk, ie_exc, ie_glb}, 32'b010);
    chk("R12 pc", redir_pc, NB + 32'd64);
    cause_req = 8'h10; cur_pc = 32'h200;
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'h5555_0000;
    tick();
    cfg_we = 1'b0; cause_req = '0;
    chk("R12 old base used", redir_pc, NB + 32'd128);
    cause_req = 8'h10;
    tick();
    cause_req = '0;
    chk("R12 new base used", redir_pc, 32'h5555_0080);
    tick();
    chk("R11 idle", {31'b0, redir_valid}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule